// File: doc/BRIEF.md
# Interrupt Status and Mask Register Block

This block gathers ten interrupt sources into one active-high interrupt line and gives software a small register window to manage them. Each source sets a sticky status bit. Software clears a status bit by writing a one to it. The mask register is read-only. Software changes it only through two write-one registers: one unmasks sources and the other masks them. A write-one trigger register lets software raise status bits without hardware, which is useful in test.

Access is over a plain 32-bit register bus with an address, a write enable with write data, and a read strobe. A write takes effect on the clock edge where the write enable is high. Read data is captured on the edge where the read strobe is high. It appears on the read data port one cycle after the strobe and holds until the next read.

Top module: `irq_regblk`

## Requirements
- R1: After reset the status register (offset 0x00) reads 0x00000000, the mask register (offset 0x04) reads 0x000003FF, and the interrupt output is low.
- R2: A source input that is high for one cycle sets its status bit. The bit stays set after the source drops.
- R3: Writing to offset 0x00 clears each status bit whose write-data bit is 1. Status bits written with 0 keep their value.
- R4: Writing to offset 0x08 clears each mask bit whose write-data bit is 1. This unmasks those sources. Other mask bits keep their value.
- R5: Writing to offset 0x0C sets each mask bit whose write-data bit is 1. This masks those sources. Other mask bits keep their value.
- R6: A write to offset 0x04 leaves the mask register unchanged.
- R7: Writing to offset 0x10 sets each status bit whose write-data bit is 1.
- R8: Offsets 0x08, 0x0C and 0x10 read as 0x00000000.
- R9: The interrupt output is high exactly when some status bit is 1 while its mask bit is 0.
- R10: A source that is high in the same cycle as a write-one clear of its status bit wins, and the bit stays 1.
- R11: Bits 31 to 10 read as zero at every offset. Writes to those bits have no effect on any register.
- R12: Read data changes only in the cycle after a read strobe and holds between strobes. An unmapped offset such as 0x20 reads 0x00000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte offset of the register being accessed |
| bus_wr | input | 1 | Write enable, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Read data, valid the cycle after the strobe |
| src_hit | input | 10 | Hardware interrupt source levels, one per status bit |
| irq_out | output | 1 | Combined active-high interrupt |

## Verification
Two events can land on the same status bit in one clock: a hardware source asserting, and a software write-one clear. The bench provokes this by holding a source high during the very cycle that a clear write is on the bus. The same write also clears a second bit that has no source active. After that edge the bench reads the status back. It expects the bit with the active source to stay 1 and the other bit to be cleared, which shows that the set takes priority bit by bit rather than blocking the whole write.

// File: rtl/irq_regblk_pkg.sv
package irq_regblk_pkg;

   localparam int unsigned OFF_STATUS  = 'h00;
   localparam int unsigned OFF_MASK    = 'h04;
   localparam int unsigned OFF_ENABLE  = 'h08;
   localparam int unsigned OFF_DISABLE = 'h0C;
   localparam int unsigned OFF_TRIGGER = 'h10;

   typedef struct packed {
      logic sel_stat;
      logic sel_mask;
      logic sel_en;
      logic sel_dis;
      logic sel_trig;
   } reg_sel_t;

endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
   import irq_regblk_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_t          sel
);

   always_comb begin
      sel.sel_stat = (addr == ADDR_W'(OFF_STATUS));
      sel.sel_mask = (addr == ADDR_W'(OFF_MASK));
      sel.sel_en   = (addr == ADDR_W'(OFF_ENABLE));
      sel.sel_dis  = (addr == ADDR_W'(OFF_DISABLE));
      sel.sel_trig = (addr == ADDR_W'(OFF_TRIGGER));
   end

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
   parameter int unsigned NUM_SRC = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_hit,
   input  logic               clr_en,
   input  logic               trig_en,
   input  logic [NUM_SRC-1:0] wdata,
   output logic [NUM_SRC-1:0] status
);

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)
            status[i] <= 1'b0;
         else
            status[i] <= src_hit[i]
                       | (trig_en & wdata[i])
                       | (status[i] & ~(clr_en & wdata[i]));
      end
   end

   assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_en |=> ((status & $past(status)) == $past(status)));

   assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (|src_hit) |=> ((status & $past(src_hit)) == $past(src_hit)));

   assert_trigger_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
      trig_en |=> ((status & $past(wdata)) == $past(wdata)));

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
   parameter int unsigned NUM_SRC = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en_wr,
   input  logic               dis_wr,
   input  logic [NUM_SRC-1:0] wdata,
   output logic [NUM_SRC-1:0] mask
);

   localparam logic [NUM_SRC-1:0] MASK_RST = '1;

   logic [NUM_SRC-1:0] unmask_bits;
   logic [NUM_SRC-1:0] mask_bits;

   assign unmask_bits = en_wr  ? wdata : '0;
   assign mask_bits   = dis_wr ? wdata : '0;

   always_ff @(posedge clk) begin
      if (!rst_n)
         mask <= MASK_RST;
      else
         mask <= (mask & ~unmask_bits) | mask_bits;
   end

   assert_enable_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (en_wr && !dis_wr) |=> ((mask & $past(wdata)) == '0));

   assert_disable_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dis_wr |=> ((mask & $past(wdata)) == $past(wdata)));

endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
   import irq_regblk_pkg::*;
#(
   parameter int unsigned NUM_SRC  = 10,
   parameter int unsigned DATA_W   = 32,
   parameter bit          READ_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rd,
   input  reg_sel_t           sel,
   input  logic [NUM_SRC-1:0] status,
   input  logic [NUM_SRC-1:0] mask,
   output logic [DATA_W-1:0]  rdata
);

   logic [DATA_W-1:0] word;

   always_comb begin
      word = '0;
      if (sel.sel_stat)      word = DATA_W'(status);
      else if (sel.sel_mask) word = DATA_W'(mask);
   end

   if (READ_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)
            rdata <= '0;
         else if (rd)
            rdata <= word;
      end

      assert_read_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
         !rd |=> $stable(rdata));
   end else begin : g_comb
      logic unused_rd_path;
      assign unused_rd_path = clk ^ rst_n ^ rd;
      assign rdata = word;
   end

endmodule

// File: rtl/irq_regblk.sv
module irq_regblk
   import irq_regblk_pkg::*;
#(
   parameter int unsigned NUM_SRC  = 10,
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 32,
   parameter bit          READ_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic [DATA_W-1:0]  bus_wdata,
   input  logic               bus_rd,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [NUM_SRC-1:0] src_hit,
   output logic               irq_out
);

   if (NUM_SRC < 1 || NUM_SRC >= DATA_W) begin : g_bad_width
      $error("irq_regblk: NUM_SRC must lie between 1 and DATA_W-1");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("irq_regblk: ADDR_W too narrow for the register window");
   end

   reg_sel_t           sel;
   logic [NUM_SRC-1:0] status;
   logic [NUM_SRC-1:0] mask;
   logic [NUM_SRC-1:0] wbits;
   logic               unused_wdata_hi;

   assign wbits           = bus_wdata[NUM_SRC-1:0];
   assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_SRC];

   irq_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
      .addr (bus_addr),
      .sel  (sel)
   );

   irq_status_bank #(.NUM_SRC(NUM_SRC)) u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_hit (src_hit),
      .clr_en  (bus_wr & sel.sel_stat),
      .trig_en (bus_wr & sel.sel_trig),
      .wdata   (wbits),
      .status  (status)
   );

   irq_mask_bank #(.NUM_SRC(NUM_SRC)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_wr  (bus_wr & sel.sel_en),
      .dis_wr (bus_wr & sel.sel_dis),
      .wdata  (wbits),
      .mask   (mask)
   );

   irq_read_mux #(
      .NUM_SRC  (NUM_SRC),
      .DATA_W   (DATA_W),
      .READ_REG (READ_REG)
   ) u_rmux (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd     (bus_rd),
      .sel    (sel),
      .status (status),
      .mask   (mask),
      .rdata  (bus_rdata)
   );

   assign irq_out = |(status & ~mask);

   assert_mask_readonly_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && sel.sel_mask) |=> $stable(mask));

   assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_out) |-> (!$stable(status) || !$stable(mask)));

   assert_upper_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[DATA_W-1:NUM_SRC] == '0);

endmodule

// File: tb/irq_regblk_tb.sv
`timescale 1ns/1ps
module irq_regblk_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [7:0]  bus_addr;
   logic        bus_wr;
   logic [31:0] bus_wdata;
   logic        bus_rd;
   logic [31:0] bus_rdata;
   logic [9:0]  src_hit;
   logic        irq_out;

   int errs   = 0;
   int checks = 0;

   always #2.5 clk = ~clk;

   irq_regblk u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rd    (bus_rd),
      .bus_rdata (bus_rdata),
      .src_hit   (src_hit),
      .irq_out   (irq_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd(8'h00, v); chk("R1 status reset", v, 32'h0);
      rd(8'h04, v); chk("R1 mask reset", v, 32'h3FF);
      chk("R1 irq reset", {31'b0, irq_out}, 32'h0);
   endtask

   task automatic t_sticky;
      logic [31:0] v;
      @(negedge clk); src_hit = 10'h005;
      @(negedge clk); src_hit = 10'h000;
      repeat (2) @(negedge clk);
      rd(8'h00, v); chk("R2 sticky status", v, 32'h005);
      chk("R9 masked source no irq", {31'b0, irq_out}, 32'h0);
   endtask

   task automatic t_enable;
      logic [31:0] v;
      wr(8'h08, 32'h001);
      rd(8'h04, v); chk("R4 enable clears mask bit", v, 32'h3FE);
      chk("R9 unmasked pending irq", {31'b0, irq_out}, 32'h1);
      rd(8'h08, v); chk("R8 enable reads zero", v, 32'h0);
   endtask

   task automatic t_w1c;
      logic [31:0] v;
      wr(8'h00, 32'h000);
      rd(8'h00, v); chk("R3 write zero keeps status", v, 32'h005);
      wr(8'h00, 32'h001);
      rd(8'h00, v); chk("R3 write one clears bit", v, 32'h004);
      chk("R9 only masked bit left", {31'b0, irq_out}, 32'h0);
   endtask

   task automatic t_disable;
      logic [31:0] v;
      wr(8'h08, 32'h3FF);
      rd(8'h04, v); chk("R4 enable all", v, 32'h000);
      chk("R9 irq after unmask", {31'b0, irq_out}, 32'h1);
      wr(8'h0C, 32'h0F0);
      rd(8'h04, v); chk("R5 disable sets mask bits", v, 32'h0F0);
      rd(8'h0C, v); chk("R8 disable reads zero", v, 32'h0);
   endtask

   task automatic t_mask_ro;
      logic [31:0] v;
      wr(8'h04, 32'hFFFF_FFFF);
      rd(8'h04, v); chk("R6 mask write ignored", v, 32'h0F0);
      wr(8'h04, 32'h0);
      rd(8'h04, v); chk("R6 mask write zero ignored", v, 32'h0F0);
   endtask

   task automatic t_trigger;
      logic [31:0] v;
      wr(8'h10, 32'h300);
      rd(8'h00, v); chk("R7 trigger sets status", v, 32'h304);
      rd(8'h10, v); chk("R8 trigger reads zero", v, 32'h0);
      wr(8'h0C, 32'h3FF);
      chk("R9 all masked no irq", {31'b0, irq_out}, 32'h0);
      wr(8'h08, 32'h30F);
      chk("R9 irq back after unmask", {31'b0, irq_out}, 32'h1);
      rd(8'h04, v); chk("R4 partial enable", v, 32'h0F0);
   endtask

   task automatic t_set_wins;
      logic [31:0] v;
      @(negedge clk);
      bus_addr = 8'h00; bus_wdata = 32'h300; bus_wr = 1'b1; src_hit = 10'h200;
      @(negedge clk);
      bus_wr = 1'b0; src_hit = 10'h000;
      rd(8'h00, v); chk("R10 set wins over clear", v, 32'h204);
   endtask

   task automatic t_upper;
      logic [31:0] v;
      wr(8'h00, 32'hFFFF_FC00);
      rd(8'h00, v); chk("R11 status clear upper ignored", v, 32'h204);
      wr(8'h08, 32'hFFFF_FC00);
      rd(8'h04, v); chk("R11 enable upper ignored", v, 32'h0F0);
      wr(8'h10, 32'hFFFF_FC00);
      rd(8'h00, v); chk("R11 trigger upper ignored", v, 32'h204);
   endtask

   task automatic t_read_hold;
      logic [31:0] v;
      rd(8'h00, v); chk("R12 read status", v, 32'h204);
      wr(8'h10, 32'h001);
      repeat (2) @(negedge clk);
      chk("R12 read data held", bus_rdata, 32'h204);
      rd(8'h00, v); chk("R12 fresh read", v, 32'h205);
      rd(8'h20, v); chk("R12 unmapped reads zero", v, 32'h0);
   endtask

   initial begin
      #(200000 * 5);
      errs++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks + 1);
      $finish;
   end

   initial begin
      rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
      bus_rd = 1'b0; src_hit = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_sticky();
      t_enable();
      t_w1c();
      t_disable();
      t_mask_ro();
      t_trigger();
      t_set_wins();
      t_upper();
      t_read_hold();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule